// File: doc/BRIEF.md
# Single-Wire Pulse-Width Bus Timing Unit

This block gives software the timing support for a single-wire serial bus. On this bus every bit period starts with a falling edge driven by the master, and the length of the low phase that follows encodes a sync pulse, a 0 or a 1. The block watches the bus input and keeps two timers. The first is a break timer clocked by a slow tick. It measures each low pulse: it restarts at the falling edge and freezes at the rising edge, so software can classify the pulse from the held count. The second is a sync timer clocked by a fast tick. It runs freely, and its value is captured on every falling edge. Software adds an offset to the captured value and writes the result to a compare input. A match then raises a flag that tells software when to release its own drive of the bus.

A start detector flags every high-to-low transition, which can wake a sleeping processor. Every action that an edge or a timer triggers takes effect only while the bus-mode enable is high. The three event flags are sticky and are cleared by write-one pulses. The interrupt output combines the flags whose enables are set. Software decodes the bits and drives the pin; this block does neither.

Top module: `pulse_bus_timer`

## Requirements
- R1: While `modeEn` is low the sync timer is held at zero, the break timer stops and keeps its count, and no edge captures, clears or sets any flag.
- R2: The bus input passes through a two-flop synchronizer that resets to high, followed by one edge-history flop. A falling edge seen while in mode clears the break timer to zero and starts it. The clear is visible two clock edges after the edge on which the input was first sampled low.
- R3: While the break timer runs, it adds one on each cycle with `slowTick` high. A synchronized rising edge stops it, and the count then holds until the next falling edge.
- R4: The break timer saturates at 2^TIMER_W-1 and does not wrap.
- R5: While in mode, the sync timer adds one on each cycle with `fastTick` high and wraps modulo 2^TIMER_W.
- R6: On each synchronized falling edge in mode, `captureValue` takes the sync timer value held during the cycle in which the edge was detected, before that cycle's increment.
- R7: `status[1]` (compare flag) is set one cycle after a cycle in which mode and `cmpIrqEn` are high and the sync timer equals `cmpValue`.
- R8: `status[0]` (pulse-end flag) is set on a synchronized rising edge in mode when `riseIrqEn` is high.
- R9: `status[2]` (start flag) is set on a synchronized falling edge in mode when `startIrqEn` is high.
- R10: Flags stay set until a 1 appears on the matching bit of `statusClr`. A set in the same cycle wins over the clear.
- R11: `irq` is high exactly when some flag is set together with its enable (bit 0 with `riseIrqEn`, bit 1 with `cmpIrqEn`, bit 2 with `startIrqEn`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busIn | input | 1 | Raw bus line |
| slowTick | input | 1 | Break timer count enable |
| fastTick | input | 1 | Sync timer count enable |
| modeEn | input | 1 | Bus-mode enable |
| riseIrqEn | input | 1 | Pulse-end flag and interrupt enable |
| cmpIrqEn | input | 1 | Compare flag and interrupt enable |
| startIrqEn | input | 1 | Start flag and interrupt enable |
| cmpValue | input | TIMER_W | Compare value for the sync timer |
| statusClr | input | 3 | Write-one-to-clear pulses for the flags |
| breakCount | output | TIMER_W | Break timer count |
| captureValue | output | TIMER_W | Sync timer value captured at the last falling edge |
| syncCount | output | TIMER_W | Sync timer count |
| status | output | 3 | Sticky flags: pulse-end, compare, start |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with TIMER_W = 8 and the default two synchronizer stages. The narrow width lets a single long low pulse drive the break timer into saturation within a few hundred cycles. It also lets the sync timer wrap many times, so compare values placed just past the wrap point are exercised. Random phases toggle the mode and enables while pulses are in flight. These phases reach pulses that began outside mode, clears that coincide with sets, and matches that recur after a flag has been cleared.

// File: rtl/pbt_pkg.sv
package pbt_pkg;
  localparam int NUM_FLAGS = 3;
  localparam int FLAG_PULSE = 0;
  localparam int FLAG_CMP = 1;
  localparam int FLAG_START = 2;

  typedef struct packed {
    logic modeOn;
    logic fall;
    logic rise;
  } pbtStrobe_t;
endpackage

// File: rtl/pbt_ctrl.sv
module pbt_ctrl
  import pbt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busIn,
  input  logic                 modeEn,
  input  logic                 riseIrqEn,
  input  logic                 cmpIrqEn,
  input  logic                 startIrqEn,
  input  logic                 cmpHit,
  input  logic [NUM_FLAGS-1:0] statusClr,
  output pbtStrobe_t           strobe,
  output logic [NUM_FLAGS-1:0] status,
  output logic                 irq
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic busNow;
  logic busPrev;
  logic [NUM_FLAGS-1:0] flagSet;
  logic [NUM_FLAGS-1:0] flagEn;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= busIn;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], busIn};
      end
    end
  endgenerate

  assign busNow = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busPrev <= 1'b1;
    else       busPrev <= busNow;
  end

  always_comb begin
    strobe.modeOn = modeEn;
    strobe.fall   = modeEn & busPrev & ~busNow;
    strobe.rise   = modeEn & ~busPrev & busNow;
  end

  always_comb begin
    flagSet = '0;
    flagSet[FLAG_PULSE] = strobe.rise & riseIrqEn;
    flagSet[FLAG_CMP]   = cmpHit & cmpIrqEn;
    flagSet[FLAG_START] = strobe.fall & startIrqEn;
    flagEn = '0;
    flagEn[FLAG_PULSE] = riseIrqEn;
    flagEn[FLAG_CMP]   = cmpIrqEn;
    flagEn[FLAG_START] = startIrqEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) status <= '0;
    else       status <= (status & ~statusClr) | flagSet;
  end

  assign irq = |(status & flagEn);
endmodule

// File: rtl/pbt_datapath.sv
module pbt_datapath
  import pbt_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  pbtStrobe_t         strobe,
  input  logic               slowTick,
  input  logic               fastTick,
  input  logic [TIMER_W-1:0] cmpValue,
  output logic [TIMER_W-1:0] breakCount,
  output logic [TIMER_W-1:0] captureValue,
  output logic [TIMER_W-1:0] syncCount,
  output logic               cmpHit
);
  localparam logic [TIMER_W-1:0] COUNT_MAX = '1;

  logic breakRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      breakCount <= '0;
      breakRun   <= 1'b0;
    end else if (!strobe.modeOn) begin
      breakRun <= 1'b0;
    end else if (strobe.fall) begin
      breakCount <= '0;
      breakRun   <= 1'b1;
    end else if (strobe.rise) begin
      breakRun <= 1'b0;
    end else if (breakRun && slowTick && breakCount != COUNT_MAX) begin
      breakCount <= breakCount + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncCount <= '0;
    end else if (!strobe.modeOn) begin
      syncCount <= '0;
    end else if (fastTick) begin
      syncCount <= syncCount + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            captureValue <= '0;
    else if (strobe.fall) captureValue <= syncCount;
  end

  assign cmpHit = strobe.modeOn & (syncCount == cmpValue);
endmodule

// File: rtl/pulse_bus_timer.sv
module pulse_bus_timer
  import pbt_pkg::*;
#(
  parameter int TIMER_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busIn,
  input  logic               slowTick,
  input  logic               fastTick,
  input  logic               modeEn,
  input  logic               riseIrqEn,
  input  logic               cmpIrqEn,
  input  logic               startIrqEn,
  input  logic [TIMER_W-1:0] cmpValue,
  input  logic [2:0]         statusClr,
  output logic [TIMER_W-1:0] breakCount,
  output logic [TIMER_W-1:0] captureValue,
  output logic [TIMER_W-1:0] syncCount,
  output logic [2:0]         status,
  output logic               irq
);
  pbtStrobe_t strobe;
  logic cmpHit;

  pbt_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .busIn(busIn), .modeEn(modeEn),
    .riseIrqEn(riseIrqEn), .cmpIrqEn(cmpIrqEn), .startIrqEn(startIrqEn),
    .cmpHit(cmpHit), .statusClr(statusClr), .strobe(strobe),
    .status(status), .irq(irq)
  );

  pbt_datapath #(.TIMER_W(TIMER_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slowTick(slowTick),
    .fastTick(fastTick), .cmpValue(cmpValue), .breakCount(breakCount),
    .captureValue(captureValue), .syncCount(syncCount), .cmpHit(cmpHit)
  );
endmodule

// File: rtl/pbt_checker.sv
module pbt_checker #(
  parameter int TIMER_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               modeEn,
  input logic               cmpIrqEn,
  input logic               fastTick,
  input logic               fall,
  input logic [TIMER_W-1:0] cmpValue,
  input logic [TIMER_W-1:0] syncCount,
  input logic [TIMER_W-1:0] captureValue,
  input logic [TIMER_W-1:0] breakCount,
  input logic [2:0]         status
);
  localparam logic [TIMER_W-1:0] COUNT_MAX = '1;

  a_r1_sync_held: assert property (@(posedge clk) disable iff (!rstN)
    !modeEn |=> syncCount == '0);

  a_r2_break_cleared: assert property (@(posedge clk) disable iff (!rstN)
    fall |=> breakCount == '0);

  a_r4_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (modeEn && !fall && breakCount == COUNT_MAX) |=> breakCount == COUNT_MAX);

  a_r5_sync_step: assert property (@(posedge clk) disable iff (!rstN)
    (modeEn && fastTick) |=> syncCount == $past(syncCount) + 1'b1);

  a_r6_capture: assert property (@(posedge clk) disable iff (!rstN)
    fall |=> captureValue == $past(syncCount));

  a_r7_cmp_flag: assert property (@(posedge clk) disable iff (!rstN)
    (modeEn && cmpIrqEn && syncCount == cmpValue) |=> status[1]);
endmodule

bind pulse_bus_timer pbt_checker #(.TIMER_W(TIMER_W)) u_chk (
  .clk(clk), .rstN(rstN), .modeEn(modeEn), .cmpIrqEn(cmpIrqEn),
  .fastTick(fastTick), .fall(strobe.fall), .cmpValue(cmpValue),
  .syncCount(syncCount), .captureValue(captureValue),
  .breakCount(breakCount), .status(status)
);

// File: tb/pulse_bus_timer_bench.sv
`timescale 1ns/1ps
module pulse_bus_timer_bench;
  localparam int BW = 8;
  localparam int MAXV = (1 << BW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busIn = 1'b1, slowTick = 1'b0, fastTick = 1'b0, modeEn = 1'b0;
  logic riseIrqEn = 1'b0, cmpIrqEn = 1'b0, startIrqEn = 1'b0;
  logic [BW-1:0] cmpValue = '0;
  logic [2:0] statusClr = '0;
  logic [BW-1:0] breakCount, captureValue, syncCount;
  logic [2:0] status;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  int q1 = 1, q2 = 1, qp = 1;
  int mBrk = 0, mSync = 0, mCap = 0;
  bit mRun = 0;
  bit [2:0] mFlags = '0;

  always #2.5 clk = ~clk;

  pulse_bus_timer #(.TIMER_W(BW), .SYNC_STAGES(2)) u_pulse_bus_timer (
    .clk(clk), .rstN(rstN), .busIn(busIn), .slowTick(slowTick),
    .fastTick(fastTick), .modeEn(modeEn), .riseIrqEn(riseIrqEn),
    .cmpIrqEn(cmpIrqEn), .startIrqEn(startIrqEn), .cmpValue(cmpValue),
    .statusClr(statusClr), .breakCount(breakCount),
    .captureValue(captureValue), .syncCount(syncCount),
    .status(status), .irq(irq)
  );

  always @(posedge clk) begin
    bit fall, rise;
    bit [2:0] setV;
    if (!rstN) begin
      q1 = 1; q2 = 1; qp = 1; mBrk = 0; mSync = 0; mCap = 0;
      mRun = 0; mFlags = '0;
    end else begin
      fall = modeEn && qp == 1 && q2 == 0;
      rise = modeEn && qp == 0 && q2 == 1;
      setV[0] = rise && riseIrqEn;
      setV[1] = modeEn && cmpIrqEn && (mSync == int'(cmpValue));
      setV[2] = fall && startIrqEn;
      if (!modeEn) begin
        mRun = 0; mSync = 0;
      end else begin
        if (fall) begin mBrk = 0; mRun = 1; mCap = mSync; end
        else if (rise) mRun = 0;
        else if (mRun && slowTick && mBrk < MAXV) mBrk++;
        if (fastTick) mSync = (mSync + 1) % (MAXV + 1);
      end
      mFlags = (mFlags & ~statusClr) | setV;
      qp = q2; q2 = q1; q1 = int'(busIn);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit expIrq;
    expIrq = |(mFlags & {startIrqEn, cmpIrqEn, riseIrqEn});
    chk(modeEn ? "R2 R3 R4 breakCount" : "R1 breakCount", int'(breakCount), mBrk);
    chk(modeEn ? "R5 syncCount" : "R1 syncCount", int'(syncCount), mSync);
    chk("R6 captureValue", int'(captureValue), mCap);
    chk("R8 R10 status0", int'(status[0]), int'(mFlags[0]));
    chk("R7 R10 status1", int'(status[1]), int'(mFlags[1]));
    chk("R9 R10 status2", int'(status[2]), int'(mFlags[2]));
    chk("R11 irq", int'(irq), int'(expIrq));
  endtask

  task automatic step(input bit b, input bit s, input bit f, input bit [2:0] clr);
    @(negedge clk);
    compareAll();
    busIn = b; slowTick = s; fastTick = f; statusClr = clr;
  endtask

  task automatic pulse(input int lowLen, input int highLen);
    for (int i = 0; i < lowLen; i++) step(1'b0, ($urandom % 2) == 0, 1'b1, 3'b000);
    for (int i = 0; i < highLen; i++) step(1'b1, ($urandom % 2) == 0, 1'b1, 3'b000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state
    chk("R1 reset breakCount", int'(breakCount), 0);
    chk("R1 reset syncCount", int'(syncCount), 0);
    chk("R10 reset status", int'(status), 0);
    chk("R11 reset irq", int'(irq), 0);
    rstN = 1'b1;
    riseIrqEn = 1; cmpIrqEn = 1; startIrqEn = 1; cmpValue = 8'd7;
    // R1: mode off, bus activity ignored
    for (int i = 0; i < 60; i++) step(1'($urandom % 2), 1'b1, 1'b1, 3'b000);
    step(1'b1, 1'b0, 1'b0, 3'b000);
    step(1'b1, 1'b0, 1'b0, 3'b000);
    step(1'b1, 1'b0, 1'b0, 3'b000);
    modeEn = 1;
    // R2 R3 R8 R9: pulses of several widths
    pulse(3, 12); pulse(10, 12); pulse(25, 15); pulse(60, 20);
    step(1'b1, 1'b0, 1'b1, 3'b111);
    // R4: long low pulse saturates break timer
    for (int i = 0; i < 300; i++) step(1'b0, 1'b1, 1'b1, 3'b000);
    step(1'b0, 1'b1, 1'b1, 3'b000);
    chk("R4 saturated", int'(breakCount), MAXV);
    pulse(0, 10);
    // R7 R10: compare around wrap, clears colliding with sets
    cmpValue = 8'd2;
    for (int i = 0; i < 700; i++) step(1'(($urandom % 40) != 0), 1'b1, ($urandom % 3) != 0,
                                        (($urandom % 6) == 0) ? 3'b111 : 3'b000);
    // random everything
    for (int i = 0; i < 3000; i++) begin
      if ((i % 97) == 0) modeEn = 1'($urandom % 4 != 0);
      if ((i % 53) == 0) begin
        riseIrqEn = 1'($urandom % 2); cmpIrqEn = 1'($urandom % 2);
        startIrqEn = 1'($urandom % 2); cmpValue = 8'($urandom);
      end
      step(1'(($urandom % 8) != 0), ($urandom % 3) == 0, ($urandom % 2) == 0,
           3'(($urandom % 5 == 0) ? $urandom : 0));
    end
    step(1'b1, 1'b0, 1'b0, 3'b000);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule